// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor that gives every procedure its own register window. An instruction names one of 32 logical registers. Registers 0 to 7 are globals seen by every procedure. Registers 8 to 15 hold the parameters passed in, 16 to 23 are private locals, and 24 to 31 hold the parameters passed out. A current window pointer (CWP) translates each logical number into an index into a larger physical array. The physical array holds the 8 globals and, for each window, 16 registers: its locals and its outgoing parameters. The incoming group of a window is the outgoing group of the window below it. A caller therefore places arguments in its outgoing registers, issues a save, and the callee finds them in its incoming registers with no copy.

The file has two combinational read ports and one write port. A save strobe moves to the next window and a restore strobe moves back to the previous one. The pointer advances modulo the window count. One window is always held back, because its outgoing group holds the incoming registers of the oldest window. So at most `NWIN-1` windows are in use at a time. A save beyond that limit raises an overflow trap, and a restore from the oldest window raises an underflow trap. In both cases the pointer does not move. Spilling windows to memory is left to a trap handler outside the block.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, both trap outputs are low and every register reads as zero.
- R2: Logical registers 0 to 7 map to the same storage in every window. A global written in one window reads back unchanged after a save or a restore.
- R3: Logical register 0 always reads as zero, and a write to it is discarded.
- R4: Outgoing register 24+k written before a save reads back as incoming register 8+k after that save. Incoming register 8+k written by the callee reads back as outgoing register 24+k of the caller after the restore.
- R5: Locals 16 to 23 are private to a window. A fresh window shows its own locals, and after a restore the caller's locals hold the values it wrote.
- R6: Each accepted save raises the pointer by one modulo `NWIN`, and each accepted restore lowers it by one. The new value appears on `cwp_o` after the clock edge that samples the strobe.
- R7: A save issued while `NWIN-1` windows are in use (with `NWIN`=6, after four net saves from reset) holds the pointer and drives `ovf_trap_o` high for exactly the one cycle after that edge.
- R8: A restore issued at the oldest window holds the pointer and drives `unf_trap_o` high for exactly the one cycle after that edge.
- R9: When a read and a write address the same register in one cycle, the read returns the old value. The new value is readable from the next cycle on.
- R10: A write issued in the same cycle as a save uses the window that was current before the save.
- R11: Save and restore asserted together are ignored. The pointer does not change and neither trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Logical register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_addr | input | 5 | Logical register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | XLEN | Write data |
| save_i | input | 1 | Move to the next window |
| restore_i | input | 1 | Return to the previous window |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_trap_o | output | 1 | One-cycle window overflow trap |
| unf_trap_o | output | 1 | One-cycle window underflow trap |

## Verification
The address translation is tested with values written in one window and read in its neighbour, one case per register group. A value that crosses through the outgoing/incoming overlap must reappear, a global must stay the same, and a local must not be shared. A wrong group decode, a swapped overlap direction or a missing offset each produce a distinct wrong read. The pointer is driven to both ends of its range to separate accepted strobes from trapped ones. Single-cycle collisions are also tested: a read and a write to the same register, a write together with a save, and save and restore together. These show whether the write address and the read data come from the pre-edge state.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int LREG_W     = 5;
    localparam int GROUP_SZ   = 8;
    localparam int GROUP_BITS = 3;
    localparam int WIN_REGS   = 2 * GROUP_SZ;
    localparam int NUM_GLOBAL = GROUP_SZ;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_IN     = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_OUT    = 2'd3
    } reg_group_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } trap_t;

    typedef struct packed {
        logic save;
        logic restore;
    } win_cmd_t;

    function automatic int unsigned wrap_inc(int unsigned w, int unsigned nwin);
        return (w == nwin - 1) ? 0 : w + 1;
    endfunction

    function automatic int unsigned wrap_dec(int unsigned w, int unsigned nwin);
        return (w == 0) ? nwin - 1 : w - 1;
    endfunction

    // Physical layout: globals first, then per window its locals and outs.
    function automatic int unsigned map_phys(logic [LREG_W-1:0] lreg,
                                             int unsigned cwp,
                                             int unsigned nwin);
        reg_group_e  grp;
        int unsigned k;
        int unsigned idx;
        grp = reg_group_e'(lreg[LREG_W-1:GROUP_BITS]);
        k   = 32'(lreg[GROUP_BITS-1:0]);
        case (grp)
            GRP_GLOBAL: idx = k;
            GRP_IN:     idx = NUM_GLOBAL + WIN_REGS * wrap_dec(cwp, nwin) + GROUP_SZ + k;
            GRP_LOCAL:  idx = NUM_GLOBAL + WIN_REGS * cwp + k;
            default:    idx = NUM_GLOBAL + WIN_REGS * cwp + GROUP_SZ + k;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 6,
    parameter int CW   = 3,
    parameter int PW   = 7
) (
    input  logic [LREG_W-1:0] lreg,
    input  logic [CW-1:0]     cwp,
    output logic [PW-1:0]     pidx,
    output logic              is_zero
);
    int unsigned full_idx;

    always_comb begin
        full_idx = map_phys(lreg, 32'(cwp), NWIN);
        pidx     = full_idx[PW-1:0];
        is_zero  = (lreg == '0);
    end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 6,
    parameter int CW   = 3,
    parameter int DW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  win_cmd_t      cmd,
    output logic [CW-1:0] cwp,
    output logic [DW-1:0] depth,
    output trap_t         trap
);
    localparam logic [DW-1:0] DEPTH_MAX = DW'(NWIN - 1);
    localparam logic [DW-1:0] DEPTH_MIN = DW'(1);

    logic [CW-1:0] cwp_up;
    logic [CW-1:0] cwp_dn;
    logic          do_save;
    logic          do_rest;

    always_comb begin
        cwp_up  = CW'(wrap_inc(32'(cwp), NWIN));
        cwp_dn  = CW'(wrap_dec(32'(cwp), NWIN));
        do_save = cmd.save && !cmd.restore;
        do_rest = cmd.restore && !cmd.save;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp   <= '0;
            depth <= DEPTH_MIN;
            trap  <= '0;
        end else begin
            trap <= '0;
            if (do_save) begin
                if (depth == DEPTH_MAX) begin
                    trap.ovf <= 1'b1;
                end else begin
                    cwp   <= cwp_up;
                    depth <= depth + DW'(1);
                end
            end else if (do_rest) begin
                if (depth == DEPTH_MIN) begin
                    trap.unf <= 1'b1;
                end else begin
                    cwp   <= cwp_dn;
                    depth <= depth - DW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int XLEN  = 32,
    parameter int NPHYS = 104,
    parameter int PW    = 7,
    parameter int NRD   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PW-1:0]            widx,
    input  logic [XLEN-1:0]          wdata,
    input  logic [NRD-1:0][PW-1:0]   ridx,
    output logic [NRD-1:0][XLEN-1:0] rdata
);
    logic [XLEN-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = mem[ridx[r]];
    end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NWIN = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [4:0]              rd_a_addr,
    output logic [XLEN-1:0]         rd_a_data,
    input  logic [4:0]              rd_b_addr,
    output logic [XLEN-1:0]         rd_b_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_addr,
    input  logic [XLEN-1:0]         wr_data,
    input  logic                    save_i,
    input  logic                    restore_i,
    output logic [$clog2(NWIN)-1:0] cwp_o,
    output logic                    ovf_trap_o,
    output logic                    unf_trap_o
);
    localparam int CW    = $clog2(NWIN);
    localparam int DW    = $clog2(NWIN + 1);
    localparam int NPHYS = NUM_GLOBAL + WIN_REGS * NWIN;
    localparam int PW    = $clog2(NPHYS);
    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 1;

    logic [CW-1:0]                cwp;
    logic [DW-1:0]                win_depth;
    trap_t                        trap;
    win_cmd_t                     cmd;
    logic [NMAP-1:0][LREG_W-1:0]  lreg_all;
    logic [NMAP-1:0][PW-1:0]      pidx_all;
    logic [NMAP-1:0]              zero_all;
    logic [NRD-1:0][PW-1:0]       ridx;
    logic [NRD-1:0][XLEN-1:0]     rraw;
    logic                         we_eff;

    assign cmd.save    = save_i;
    assign cmd.restore = restore_i;

    rwin_ctrl #(.NWIN(NWIN), .CW(CW), .DW(DW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .cwp   (cwp),
        .depth (win_depth),
        .trap  (trap)
    );

    // Port order: read A, read B, write.
    assign lreg_all[0] = rd_a_addr;
    assign lreg_all[1] = rd_b_addr;
    assign lreg_all[2] = wr_addr;

    for (genvar p = 0; p < NMAP; p++) begin : g_map
        rwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .lreg    (lreg_all[p]),
            .cwp     (cwp),
            .pidx    (pidx_all[p]),
            .is_zero (zero_all[p])
        );
    end

    for (genvar r = 0; r < NRD; r++) begin : g_ridx
        assign ridx[r] = pidx_all[r];
    end

    assign we_eff = wr_en && !zero_all[NRD];

    rwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (we_eff),
        .widx  (pidx_all[NRD]),
        .wdata (wr_data),
        .ridx  (ridx),
        .rdata (rraw)
    );

    assign rd_a_data  = zero_all[0] ? '0 : rraw[0];
    assign rd_b_data  = zero_all[1] ? '0 : rraw[1];
    assign cwp_o      = cwp;
    assign ovf_trap_o = trap.ovf;
    assign unf_trap_o = trap.unf;
endmodule

// File: rtl/rwin_checker.sv
module rwin_checker #(
    parameter int XLEN = 32,
    parameter int NWIN = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic [4:0]              rd_a_addr,
    input logic [XLEN-1:0]         rd_a_data,
    input logic [4:0]              rd_b_addr,
    input logic [XLEN-1:0]         rd_b_data,
    input logic                    save_i,
    input logic                    restore_i,
    input logic [$clog2(NWIN)-1:0] cwp_o,
    input logic                    ovf_trap_o,
    input logic                    unf_trap_o
);
    localparam int CW = $clog2(NWIN);

    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    function automatic logic [CW-1:0] nxt(logic [CW-1:0] w);
        return (32'(w) == NWIN - 1) ? '0 : w + CW'(1);
    endfunction

    function automatic logic [CW-1:0] prv(logic [CW-1:0] w);
        return (w == '0) ? CW'(NWIN - 1) : w - CW'(1);
    endfunction

    assert_zero_read_a_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == 5'd0) |-> (rd_a_data == '0));
    assert_zero_read_b_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == 5'd0) |-> (rd_b_data == '0));

    assert_save_step_R6: assert property (@(posedge clk) disable iff (rst)
        (started && $past(save_i && !restore_i) && !ovf_trap_o) |-> (cwp_o == nxt($past(cwp_o))));
    assert_restore_step_R6: assert property (@(posedge clk) disable iff (rst)
        (started && $past(restore_i && !save_i) && !unf_trap_o) |-> (cwp_o == prv($past(cwp_o))));

    assert_ovf_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (started && ovf_trap_o) |-> (cwp_o == $past(cwp_o) && $past(save_i)));
    assert_unf_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (started && unf_trap_o) |-> (cwp_o == $past(cwp_o) && $past(restore_i)));
    assert_traps_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap_o && unf_trap_o));

    assert_both_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (started && $past(save_i && restore_i)) |-> (cwp_o == $past(cwp_o) && !ovf_trap_o && !unf_trap_o));
endmodule

bind rwin_regfile rwin_checker #(.XLEN(XLEN), .NWIN(NWIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_a_addr  (rd_a_addr),
    .rd_a_data  (rd_a_data),
    .rd_b_addr  (rd_b_addr),
    .rd_b_data  (rd_b_data),
    .save_i     (save_i),
    .restore_i  (restore_i),
    .cwp_o      (cwp_o),
    .ovf_trap_o (ovf_trap_o),
    .unf_trap_o (unf_trap_o)
);

// File: tb/rwin_regfile_tb_top.sv
`timescale 1ns/1ps
module rwin_regfile_tb_top;
    localparam int XLEN = 32;
    localparam int NWIN = 6;
    localparam int CW   = $clog2(NWIN);

    logic            clk = 1'b0;
    logic            rst;
    logic [4:0]      rd_a_addr, rd_b_addr, wr_addr;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
    logic            wr_en, save_i, restore_i;
    logic [CW-1:0]   cwp_o;
    logic            ovf_trap_o, unf_trap_o;

    int n_cmp = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    rwin_regfile #(.XLEN(XLEN), .NWIN(NWIN)) dut_i (
        .clk (clk), .rst (rst),
        .rd_a_addr (rd_a_addr), .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr), .rd_b_data (rd_b_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .save_i (save_i), .restore_i (restore_i),
        .cwp_o (cwp_o), .ovf_trap_o (ovf_trap_o), .unf_trap_o (unf_trap_o)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        rd_a_addr = a;
        #1 d = rd_a_data;
    endtask

    task automatic do_save();
        save_i = 1'b1; tick(); save_i = 1'b0;
    endtask

    task automatic do_restore();
        restore_i = 1'b1; tick(); restore_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 cwp", 32'(cwp_o), 0);
        check("R1 ovf", 32'(ovf_trap_o), 0);
        check("R1 unf", 32'(unf_trap_o), 0);
        rd(5'd5, v);  check("R1 r5", v, 0);
        rd(5'd29, v); check("R1 r29", v, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(5'd0, 32'hDEAD_BEEF);
        rd(5'd0, v); check("R3 r0 port A", v, 0);
        rd_b_addr = 5'd0;
        #1 check("R3 r0 port B", rd_b_data, 0);
    endtask

    task automatic t_globals();
        logic [31:0] v;
        wr(5'd3, 32'h0000_0A03);
        do_save();
        rd(5'd3, v); check("R2 global after save", v, 32'h0000_0A03);
        wr(5'd6, 32'h0000_0B06);
        do_restore();
        rd(5'd6, v); check("R2 global after restore", v, 32'h0000_0B06);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        wr(5'd26, 32'h1111_2626);
        do_save();
        rd(5'd10, v); check("R4 out->in", v, 32'h1111_2626);
        wr(5'd12, 32'h2222_1212);
        do_restore();
        rd(5'd28, v); check("R4 in->out", v, 32'h2222_1212);
    endtask

    task automatic t_locals();
        logic [31:0] v;
        wr(5'd17, 32'hAAAA_0017);
        do_save();
        rd(5'd17, v); check("R5 fresh local", v, 0);
        wr(5'd17, 32'hBBBB_0017);
        do_restore();
        rd(5'd17, v); check("R5 caller local kept", v, 32'hAAAA_0017);
    endtask

    task automatic t_cwp();
        do_save();    check("R6 save step", 32'(cwp_o), 1);
        do_save();    check("R6 second save", 32'(cwp_o), 2);
        do_restore(); check("R6 restore step", 32'(cwp_o), 1);
        do_restore(); check("R6 back to 0", 32'(cwp_o), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < NWIN - 2; i++) begin
            do_save();
            check("R7 no early ovf", 32'(ovf_trap_o), 0);
        end
        check("R7 cwp at limit", 32'(cwp_o), NWIN - 2);
        do_save();
        check("R7 ovf raised", 32'(ovf_trap_o), 1);
        check("R7 cwp held", 32'(cwp_o), NWIN - 2);
        tick();
        check("R7 ovf one cycle", 32'(ovf_trap_o), 0);
        for (int i = 0; i < NWIN - 2; i++) begin
            do_restore();
        end
        check("R7 unwound", 32'(cwp_o), 0);
    endtask

    task automatic t_underflow();
        do_restore();
        check("R8 unf raised", 32'(unf_trap_o), 1);
        check("R8 cwp held", 32'(cwp_o), 0);
        tick();
        check("R8 unf one cycle", 32'(unf_trap_o), 0);
    endtask

    task automatic t_rdw();
        logic [31:0] v;
        wr(5'd20, 32'h0000_0020);
        wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h0000_1020;
        rd(5'd20, v); check("R9 old value same cycle", v, 32'h0000_0020);
        tick();
        wr_en = 1'b0;
        rd(5'd20, v); check("R9 new value next cycle", v, 32'h0000_1020);
    endtask

    task automatic t_save_write();
        logic [31:0] v;
        wr_en = 1'b1; wr_addr = 5'd27; wr_data = 32'h5A5A_0027;
        save_i = 1'b1;
        tick();
        wr_en = 1'b0; save_i = 1'b0;
        check("R10 cwp moved", 32'(cwp_o), 1);
        rd(5'd11, v); check("R10 write used old window", v, 32'h5A5A_0027);
        do_restore();
    endtask

    task automatic t_both();
        do_save();
        save_i = 1'b1; restore_i = 1'b1;
        tick();
        save_i = 1'b0; restore_i = 1'b0;
        check("R11 cwp unchanged", 32'(cwp_o), 1);
        check("R11 no ovf", 32'(ovf_trap_o), 0);
        check("R11 no unf", 32'(unf_trap_o), 0);
        do_restore();
    endtask

    initial begin
        #4_000_000;
        n_cmp++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0; save_i = 1'b0; restore_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_globals();
        t_overlap();
        t_locals();
        t_cwp();
        t_overflow();
        t_underflow();
        t_rdw();
        t_save_write();
        t_both();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule